// File: doc/BRIEF.md
# Processor status register with interrupt gating

This block is the 8-bit flag register of a small processor core. It keeps the global interrupt enable, a one-bit scratch flag used by the bit-copy instructions, and six arithmetic flags. The ALU updates flags one by one under individual enables. The interrupt controller reports when an interrupt is taken and when a handler returns. Software reads and writes the whole register through the I/O space.

The register also combines the global enable with the per-source pending and mask bits and produces the single interrupt request that goes to the core. It computes the result of a bit-load instruction, which is a register operand with one bit replaced by the scratch flag. The sign flag is held equal to the exclusive-or of the negative and overflow flags at all times.

Top module: `cpu_sreg`

## Requirements
- R1: After reset all eight bits of `sreg_o` are 0 and `irq_req` is 0.
- R2: The bit layout from bit 7 down to bit 0 is I, T, H, S, V, N, Z, C. When `io_addr` is 0x3F, `io_rdata` shows the register; at any other address `io_rdata` is 0. A write at 0x3F loads the register one cycle later. A write at any other address changes no bit.
- R3: `irq_accept` clears I (bit 7) on the next cycle. It wins over `irq_return` and over an I/O write in the same cycle.
- R4: `irq_return` sets I on the next cycle. It wins over an I/O write in the same cycle.
- R5: S (bit 4) always equals N (bit 2) xor V (bit 3). The S value in written data is ignored.
- R6: `irq_req` equals I AND the OR over all sources of `src_pending & src_enable`. It is combinational.
- R7: `alu_en` and `alu_val` use the register bit positions. Only bits 5, 3, 2, 1 and 0 (H, V, N, Z, C) take effect, and a flag whose enable is 0 keeps its value. Enables at bits 7, 6 and 4 have no effect.
- R8: An I/O write in the same cycle as ALU updates or a bit store takes priority for every bit except I.
- R9: `bst_en` copies `bst_src[bit_sel]` into T (bit 6) on the next cycle.
- R10: `bld_result` equals `bld_src` with bit `bit_sel` replaced by the current T. It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O-space address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| alu_en | input | 8 | Per-flag update enables |
| alu_val | input | 8 | Per-flag new values |
| bst_en | input | 1 | Bit-store request |
| bst_src | input | 8 | Bit-store operand |
| bit_sel | input | 3 | Bit index for store and load |
| bld_src | input | 8 | Bit-load operand |
| bld_result | output | 8 | Bit-load result |
| irq_accept | input | 1 | Interrupt taken this cycle |
| irq_return | input | 1 | Return from interrupt this cycle |
| src_pending | input | 4 | Per-source pending bits |
| src_enable | input | 4 | Per-source mask bits |
| irq_req | output | 1 | Gated interrupt request |
| sreg_o | output | 8 | Current register value |

## Verification
The hardest case to reach is several writers hitting the same bit in one cycle. Examples are an interrupt accept and a return landing together with an I/O write that sets I, or an I/O write arriving alongside ALU enables and a bit store. The stimulus drives every one of these sources on the same clock edge. It uses written data that disagrees with each competing source, so that only the correct winner produces the expected value. The sign flag gets the same treatment: the data writes an S bit that contradicts N xor V.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  localparam int REG_W  = 8;
  localparam int I_POS  = 7;
  localparam int T_POS  = 6;
  localparam int H_POS  = 5;
  localparam int S_POS  = 4;
  localparam int V_POS  = 3;
  localparam int N_POS  = 2;
  localparam int Z_POS  = 1;
  localparam int C_POS  = 0;

  // sign flag rule: negative xor two's-complement overflow
  function automatic logic sign_of(input logic n, input logic v);
    return n ^ v;
  endfunction

  // true for the flags the ALU may update
  function automatic bit is_arith(input int b);
    return (b == H_POS) || (b == V_POS) || (b == N_POS) ||
           (b == Z_POS) || (b == C_POS);
  endfunction
endpackage

// File: rtl/sreg_flag_file.sv
`timescale 1ns/1ps
module sreg_flag_file
  import sreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] alu_en,
  input  logic [REG_W-1:0] alu_val,
  input  logic             t_we,
  input  logic             t_val,
  input  logic             i_clr,
  input  logic             i_set,
  output logic [REG_W-1:0] flags_q
);
  logic [REG_W-1:0] flags_d;

  // per-bit next-state, priority chosen by bit role
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b == I_POS) begin : g_i
      assign flags_d[b] = i_clr  ? 1'b0 :
                          i_set  ? 1'b1 :
                          wr_hit ? wr_data[b] : flags_q[b];
    end else if (b == T_POS) begin : g_t
      assign flags_d[b] = wr_hit ? wr_data[b] :
                          t_we   ? t_val : flags_q[b];
    end else if (b == S_POS) begin : g_s
      assign flags_d[b] = sign_of(flags_d[N_POS], flags_d[V_POS]);
    end else begin : g_arith
      assign flags_d[b] = wr_hit    ? wr_data[b] :
                          alu_en[b] ? alu_val[b] : flags_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/sreg_bitcopy.sv
`timescale 1ns/1ps
module sreg_bitcopy #(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] bst_src,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              t_cur,
  input  logic [DATA_W-1:0] bld_src,
  output logic              t_pick,
  output logic [DATA_W-1:0] bld_result
);
  assign t_pick = bst_src[bit_sel];

  for (genvar b = 0; b < DATA_W; b++) begin : g_ins
    assign bld_result[b] = (bit_sel == SEL_W'(b)) ? t_cur : bld_src[b];
  end
endmodule

// File: rtl/sreg_irq_gate.sv
`timescale 1ns/1ps
module sreg_irq_gate #(
  parameter int NUM_SRC = 4
) (
  input  logic               gie,
  input  logic [NUM_SRC-1:0] src_pending,
  input  logic [NUM_SRC-1:0] src_enable,
  output logic               irq_req
);
  logic [NUM_SRC-1:0] live;
  assign live    = src_pending & src_enable;
  assign irq_req = gie & (|live);
endmodule

// File: rtl/cpu_sreg.sv
`timescale 1ns/1ps
module cpu_sreg
  import sreg_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter logic [5:0]  SREG_ADDR = 6'h3F,
  parameter int          NUM_SRC   = 4,
  localparam int         SEL_W     = $clog2(REG_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic [REG_W-1:0]   io_wdata,
  output logic [REG_W-1:0]   io_rdata,
  input  logic [REG_W-1:0]   alu_en,
  input  logic [REG_W-1:0]   alu_val,
  input  logic               bst_en,
  input  logic [REG_W-1:0]   bst_src,
  input  logic [SEL_W-1:0]   bit_sel,
  input  logic [REG_W-1:0]   bld_src,
  output logic [REG_W-1:0]   bld_result,
  input  logic               irq_accept,
  input  logic               irq_return,
  input  logic [NUM_SRC-1:0] src_pending,
  input  logic [NUM_SRC-1:0] src_enable,
  output logic               irq_req,
  output logic [REG_W-1:0]   sreg_o
);
  // named events for the checker
  logic io_hit;
  logic ev_io_write;
  logic ev_i_clear;
  logic ev_i_set;
  logic t_pick;
  logic [REG_W-1:0] flags_q;

  assign io_hit      = (io_addr == ADDR_W'(SREG_ADDR));
  assign ev_io_write = io_hit & io_wr;
  assign ev_i_clear  = irq_accept;
  assign ev_i_set    = irq_return & ~irq_accept;

  sreg_flag_file u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (ev_io_write),
    .wr_data (io_wdata),
    .alu_en  (alu_en),
    .alu_val (alu_val),
    .t_we    (bst_en),
    .t_val   (t_pick),
    .i_clr   (ev_i_clear),
    .i_set   (irq_return),
    .flags_q (flags_q)
  );

  sreg_bitcopy #(.DATA_W(REG_W)) u_bits (
    .bst_src    (bst_src),
    .bit_sel    (bit_sel),
    .t_cur      (flags_q[T_POS]),
    .bld_src    (bld_src),
    .t_pick     (t_pick),
    .bld_result (bld_result)
  );

  sreg_irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .gie         (flags_q[I_POS]),
    .src_pending (src_pending),
    .src_enable  (src_enable),
    .irq_req     (irq_req)
  );

  assign io_rdata = io_hit ? flags_q : '0;
  assign sreg_o   = flags_q;
endmodule

// File: rtl/cpu_sreg_chk.sv
`timescale 1ns/1ps
module cpu_sreg_chk #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         sreg_o,
  input logic               irq_req,
  input logic               ev_io_write,
  input logic               ev_i_clear,
  input logic               ev_i_set,
  input logic [7:0]         io_wdata,
  input logic [7:0]         alu_en,
  input logic               bst_en,
  input logic [7:0]         bst_src,
  input logic [2:0]         bit_sel,
  input logic [NUM_SRC-1:0] src_pending,
  input logic [NUM_SRC-1:0] src_enable
);
  assert_i_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i_clear |=> !sreg_o[7]);

  assert_i_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i_set |=> sreg_o[7]);

  assert_sign_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_o[4] == (sreg_o[2] ^ sreg_o[3]));

  assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sreg_o[7] |-> !irq_req);

  assert_req_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_o[7] && |(src_pending & src_enable)) |-> irq_req);

  assert_carry_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_io_write && !alu_en[0]) |=> sreg_o[0] == $past(sreg_o[0]));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_io_write |=> (sreg_o[6:5] == $past(io_wdata[6:5])) &&
                    (sreg_o[3:0] == $past(io_wdata[3:0])));

  assert_bit_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_en && !ev_io_write) |=> sreg_o[6] == $past(bst_src[bit_sel]));
endmodule

bind cpu_sreg cpu_sreg_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sreg_o      (sreg_o),
  .irq_req     (irq_req),
  .ev_io_write (ev_io_write),
  .ev_i_clear  (ev_i_clear),
  .ev_i_set    (ev_i_set),
  .io_wdata    (io_wdata),
  .alu_en      (alu_en),
  .bst_en      (bst_en),
  .bst_src     (bst_src),
  .bit_sel     (bit_sel),
  .src_pending (src_pending),
  .src_enable  (src_enable)
);

// File: tb/cpu_sreg_tb.sv
`timescale 1ns/1ps
module cpu_sreg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [7:0] alu_en = '0, alu_val = '0;
  logic       bst_en = 1'b0;
  logic [7:0] bst_src = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] bld_src = '0;
  logic [7:0] bld_result;
  logic       irq_accept = 1'b0, irq_return = 1'b0;
  logic [3:0] src_pending = '0, src_enable = '0;
  logic       irq_req;
  logic [7:0] sreg_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cpu_sreg u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .alu_en(alu_en),
    .alu_val(alu_val), .bst_en(bst_en), .bst_src(bst_src),
    .bit_sel(bit_sel), .bld_src(bld_src), .bld_result(bld_result),
    .irq_accept(irq_accept), .irq_return(irq_return),
    .src_pending(src_pending), .src_enable(src_enable),
    .irq_req(irq_req), .sreg_o(sreg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected register value per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), 32'(sreg_o), 32'(exp_q.pop_front()));
    end
  end

  task automatic idle();
    io_wr = 0; io_addr = '0; io_wdata = '0; alu_en = '0; alu_val = '0;
    bst_en = 0; irq_accept = 0; irq_return = 0;
  endtask

  // driver: model applies sources lowest priority first, so higher ones overwrite
  task automatic cycle(input string tag);
    logic [7:0] nx;
    nx = model;
    foreach (nx[b]) if (b inside {0, 1, 2, 3, 5} && alu_en[b]) nx[b] = alu_val[b];
    if (bst_en) nx[6] = bst_src[bit_sel];
    if (io_wr && io_addr == 6'h3F) nx = io_wdata;
    if (irq_return) nx[7] = 1'b1;
    if (irq_accept) nx[7] = 1'b0;
    nx[4] = nx[2] ^ nx[3];
    model = nx;
    exp_q.push_back(nx);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic io_write(input logic [5:0] a, input logic [7:0] d, input string tag);
    io_addr = a; io_wr = 1; io_wdata = d;
    cycle(tag);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value", 32'(sreg_o), 0);
    chk("R1 reset irq", 32'(irq_req), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 write and read at 0x3F; R5 S forced from N,V
    io_write(6'h3F, 8'h6B, "R2 write all bits");
    io_addr = 6'h3F; #1;
    chk("R2 read hit", 32'(io_rdata), 32'(model));
    io_addr = 6'h05; #1;
    chk("R2 read miss", 32'(io_rdata), 0);
    io_write(6'h05, 8'hFF, "R2 other address ignored");
    io_write(6'h3F, 8'h10, "R5 S ignored in write data");
    io_write(6'h3F, 8'h04, "R5 S from N");

    // R7 partial ALU updates, enables at 7,6,4 ignored
    alu_en = 8'b1101_0001; alu_val = 8'hFF;
    cycle("R7 carry only, I T S enables ignored");
    alu_en = 8'b0010_1000; alu_val = 8'b0010_1000;
    cycle("R7 H and V update");
    alu_en = 8'b0000_0110; alu_val = 8'b0000_0010;
    cycle("R7 N clear Z set");

    // R8 write beats ALU and bit store
    io_addr = 6'h3F; io_wr = 1; io_wdata = 8'h00;
    alu_en = 8'hFF; alu_val = 8'hFF; bst_en = 1; bst_src = 8'hFF; bit_sel = 3'd2;
    cycle("R8 write over ALU and store");

    // R9 bit store
    bst_en = 1; bst_src = 8'b0010_0000; bit_sel = 3'd5;
    cycle("R9 store one");
    bld_src = 8'h00; bit_sel = 3'd3; #1;
    chk("R10 load T=1 at bit 3", 32'(bld_result), 32'h08);
    bld_src = 8'hFF; bit_sel = 3'd7; #1;
    chk("R10 load T=1 keeps others", 32'(bld_result), 32'hFF);
    bst_en = 1; bst_src = 8'b1111_1110; bit_sel = 3'd0;
    cycle("R9 store zero");
    bld_src = 8'hFF; bit_sel = 3'd6; #1;
    chk("R10 load T=0 at bit 6", 32'(bld_result), 32'hBF);

    // R6 gating
    io_write(6'h3F, 8'h80, "R2 set I");
    src_pending = 4'b0100; src_enable = 4'b0100; #1;
    chk("R6 pending and enabled", 32'(irq_req), 1);
    src_enable = 4'b1011; #1;
    chk("R6 masked", 32'(irq_req), 0);
    src_enable = 4'b0100;

    // R3 accept beats return and write
    irq_accept = 1; irq_return = 1; io_addr = 6'h3F; io_wr = 1; io_wdata = 8'h80;
    cycle("R3 accept wins");
    #1;
    chk("R6 request off after accept", 32'(irq_req), 0);
    // R4 return beats write of I=0
    irq_return = 1; io_addr = 6'h3F; io_wr = 1; io_wdata = 8'h2F;
    cycle("R4 return wins over write");
    #1;
    chk("R6 request back after return", 32'(irq_req), 1);
    irq_accept = 1;
    cycle("R3 plain accept");
    irq_return = 1;
    cycle("R4 plain return");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule